// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a general-purpose pin controller for up to 32 pins. Software reaches it through a 32-bit register port in the APB style. For each pin, software can choose whether the GPIO logic or an alternate function owns the pin. It can also set the pin direction, gate the output driver and set the driven level. The level on each pin is read back after it has been synchronised to the block clock.

Every pin can raise an interrupt. The trigger is either a level (high or low) or an edge (rising, falling or both). A detected condition is latched into a status register whether or not the pin is masked. A read of the status register returns the latched bits and clears them in the same access, so there is no separate acknowledge register. The mask is changed only through a write-one-to-unmask register and a write-one-to-mask register. A single interrupt line is raised whenever a latched bit belongs to an unmasked pin.

A bus transfer uses two phases:
- Setup phase: `psel` high and `penable` low.
- Access phase: `psel` and `penable` both high.

Writes take effect at the clock edge that ends the access phase. Read data is captured at the edge that ends the setup phase and is held on `prdata` through the access phase.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask register (0x14) reads all ones over the pin bits and the direction register (0x04) reads all ones. Every other register reads zero, and `irq` is low.
- R2: The bypass (0x00), direction (0x04), output enable (0x08), output level (0x0C), trigger kind (0x24), polarity (0x28) and both-edges (0x2C) registers read back the last value written to their pin bits.
- R3: Register bits at and above the pin count read as zero and ignore writes. Reads of unmapped offsets (0x30 to 0x3C, and any address at 0x40 or above) return zero. Reads of the unmask (0x18) and mask (0x1C) registers also return zero.
- R4: `pin_out` follows the output level register. `pin_alt_sel` follows the bypass register. A bit of `pin_oe` is 1 only when that pin's output enable bit is 1, its direction bit is 0 (0 = output, 1 = input) and its bypass bit is 0 (1 = alternate function owns the pin).
- R5: The input register (0x10) returns `pin_in` after a two-flop synchroniser, so a change at the pin is visible to a read whose setup phase ends three or more clock edges later.
- R6: Writing 1 to a bit of 0x18 clears that pin's mask bit, and writing 1 to a bit of 0x1C sets it. Bits written as 0 leave the mask unchanged. The mask is read at 0x14, where 1 means masked.
- R7: With trigger kind bit = 1 the pin is level-sensitive. Polarity bit 1 means active-high and 0 means active-low. The status bit is set on every cycle the synchronised level matches.
- R8: With trigger kind bit = 0 the pin is edge-sensitive on the synchronised signal. If its both-edges bit is 1, either edge triggers. Otherwise polarity 1 selects rising edges and 0 selects falling edges, and the other edge sets nothing.
- R9: The status register (0x20) latches detected conditions regardless of the mask. A read returns the latched bits and clears them. A condition present at the clearing edge keeps its bit set, so a level that is still active reads 1 again.
- R10: `irq` is high exactly when some status bit is set for an unmasked pin.
- R11: Writes to the input (0x10), mask readback (0x14) and status (0x20) registers have no effect. The same holds for writes to unmapped offsets and to addresses at or above 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Level to drive on each pin |
| pin_oe | output | NPINS | Output driver enable per pin |
| pin_alt_sel | output | NPINS | 1 = alternate function owns the pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The interrupt logic is swept over every pin of an eight-pin build, in six trigger modes:
- level-high and level-low;
- rising only and falling only;
- both edges, entered by a rise and by a fall.

For each mode, each pin is first driven to the active value and then back to the idle value, so the sweep covers both directions of change. This separates a one-shot edge latch from a level that re-arms after a clearing read. It also shows that a single-edge mode ignores the opposite edge, while the both-edges mode catches it.

Register readback is tried with all-ones and with alternating bit patterns, which expose lost upper bits and bit swaps. Pin-driver gating is tried over combinations of direction, enable and bypass. Writes to read-only, unmapped and aliased addresses are each followed by readbacks, to show that no register changed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index of each register: byte address bits [5:2].
  typedef enum logic [3:0] {
    RI_BYPASS = 4'd0,
    RI_DIR    = 4'd1,
    RI_OE     = 4'd2,
    RI_OUT    = 4'd3,
    RI_IN     = 4'd4,
    RI_MASK   = 4'd5,
    RI_UNMASK = 4'd6,
    RI_SETMSK = 4'd7,
    RI_STAT   = 4'd8,
    RI_KIND   = 4'd9,
    RI_POL    = 4'd10,
    RI_BOTH   = 4'd11
  } reg_idx_e;

  localparam int unsigned BUS_W   = 32;
  localparam int unsigned WIN_LSB = 6;  // the register window spans 64 bytes

endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,   // synchronised level
  output logic [W-1:0] prev_o   // synchronised level one cycle earlier
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= pin_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[k] <= '0;
      else     chain_q[k] <= chain_q[k-1];
    end
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_sel,   // 1 = level, 0 = edge
  input  logic [W-1:0] pol,       // 1 = high / rising
  input  logic [W-1:0] both,      // 1 = either edge
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status_o,
  output logic [W-1:0] fire_o
);

  for (genvar b = 0; b < W; b++) begin : g_pin
    logic rise, fall, lvl_hit, edge_hit;
    assign rise     = cur[b] & ~prev[b];
    assign fall     = ~cur[b] & prev[b];
    assign lvl_hit  = pol[b] ? cur[b] : ~cur[b];
    assign edge_hit = both[b] ? (rise | fall) : (pol[b] ? rise : fall);
    assign fire_o[b] = lvl_sel[b] ? lvl_hit : edge_hit;
  end

  logic [W-1:0] status_q;
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_en ? clr_bits : '0;

  // A new condition overrides a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | fire_o;
  end

  assign status_o = status_q;

  // R9: without a clearing access, latched bits stay set
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R9: a detected condition is always latched, even during a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|fire_o) |=> ((status_o & $past(fire_o)) == $past(fire_o)));

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  input  logic [W-1:0]      in_val,
  input  logic [W-1:0]      status,
  output logic [BUS_W-1:0]  prdata,
  output logic [W-1:0]      byp_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      kind_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      both_o,
  output logic              clr_en,
  output logic [W-1:0]      clr_bits
);

  logic     in_win, wr_acc, rd_setup, rd_acc;
  reg_idx_e idx;
  logic [W-1:0] wd;

  assign in_win   = ((paddr >> WIN_LSB) == '0) && (paddr[1:0] == 2'b00);
  assign idx      = reg_idx_e'(paddr[5:2]);
  assign wr_acc   = psel & penable & pwrite & in_win;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign rd_acc   = psel & penable & ~pwrite & in_win;
  assign wd       = pwdata[W-1:0];

  logic [W-1:0] byp_q, dir_q, oe_q, out_q, mask_q, kind_q, pol_q, both_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q  <= '0;
      dir_q  <= '1;
      oe_q   <= '0;
      out_q  <= '0;
      mask_q <= '1;
      kind_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else if (wr_acc) begin
      case (idx)
        RI_BYPASS: byp_q  <= wd;
        RI_DIR:    dir_q  <= wd;
        RI_OE:     oe_q   <= wd;
        RI_OUT:    out_q  <= wd;
        RI_UNMASK: mask_q <= mask_q & ~wd;
        RI_SETMSK: mask_q <= mask_q | wd;
        RI_KIND:   kind_q <= wd;
        RI_POL:    pol_q  <= wd;
        RI_BOTH:   both_q <= wd;
        default:   ;
      endcase
    end
  end

  logic [W-1:0]     rd_mux;
  logic [BUS_W-1:0] rd_word;

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (idx)
        RI_BYPASS: rd_mux = byp_q;
        RI_DIR:    rd_mux = dir_q;
        RI_OE:     rd_mux = oe_q;
        RI_OUT:    rd_mux = out_q;
        RI_IN:     rd_mux = in_val;
        RI_MASK:   rd_mux = mask_q;
        RI_STAT:   rd_mux = status;
        RI_KIND:   rd_mux = kind_q;
        RI_POL:    rd_mux = pol_q;
        RI_BOTH:   rd_mux = both_q;
        default:   rd_mux = '0;
      endcase
    end
    rd_word = '0;
    rd_word[W-1:0] = rd_mux;
  end

  logic [BUS_W-1:0] prdata_q;
  logic [W-1:0]     snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata_q <= '0;
      snap_q   <= '0;
    end else if (rd_setup) begin
      prdata_q <= rd_word;
      snap_q   <= (in_win && idx == RI_STAT) ? status : '0;
    end
  end

  assign prdata   = prdata_q;
  assign clr_en   = rd_acc && (idx == RI_STAT);
  assign clr_bits = snap_q;

  assign byp_o  = byp_q;
  assign dir_o  = dir_q;
  assign oe_o   = oe_q;
  assign out_o  = out_q;
  assign mask_o = mask_q;
  assign kind_o = kind_q;
  assign pol_o  = pol_q;
  assign both_o = both_q;

  // R6: a one written to the unmask register leaves that pin unmasked
  a_r6_unmask: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && idx == RI_UNMASK) |=> ((mask_o & $past(wd)) == '0));

  // R6: a one written to the mask register leaves that pin masked
  a_r6_setmask: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && idx == RI_SETMSK) |=> ((mask_o & $past(wd)) == $past(wd)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_alt_sel,
  output logic              irq
);

  logic [NPINS-1:0] cur, prev, status, fire;
  logic [NPINS-1:0] byp, dir, oe, outv, mask, kind, pol, both;
  logic [NPINS-1:0] clr_bits;
  logic             clr_en;

  gpio_sync_bank #(.W(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_in),
    .cur_o  (cur),
    .prev_o (prev)
  );

  gpio_reg_bank #(.W(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .in_val   (cur),
    .status   (status),
    .prdata   (prdata),
    .byp_o    (byp),
    .dir_o    (dir),
    .oe_o     (oe),
    .out_o    (outv),
    .mask_o   (mask),
    .kind_o   (kind),
    .pol_o    (pol),
    .both_o   (both),
    .clr_en   (clr_en),
    .clr_bits (clr_bits)
  );

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .lvl_sel  (kind),
    .pol      (pol),
    .both     (both),
    .cur      (cur),
    .prev     (prev),
    .clr_en   (clr_en),
    .clr_bits (clr_bits),
    .status_o (status),
    .fire_o   (fire)
  );

  assign pin_out     = outv;
  assign pin_alt_sel = byp;
  assign pin_oe      = oe & ~dir & ~byp;
  assign irq         = |(status & ~mask);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

  localparam int unsigned NP = 8;
  localparam logic [31:0] PM = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_alt_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(8)) i_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt_sel(pin_alt_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rdchk("R1 bypass", 8'h00, 0);
    rdchk("R1 dir", 8'h04, PM);
    rdchk("R1 oe", 8'h08, 0);
    rdchk("R1 out", 8'h0C, 0);
    rdchk("R1 mask", 8'h14, PM);
    rdchk("R1 status", 8'h20, 0);
    rdchk("R1 kind", 8'h24, 0);
    rdchk("R1 pol", 8'h28, 0);
    rdchk("R1 both", 8'h2C, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 / R3 readback and upper bits
    foreach (d[i]) ;
    for (int pat = 0; pat < 3; pat++) begin
      logic [31:0] v;
      v = (pat == 0) ? 32'hFFFF_FFFF : (pat == 1) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
      for (int r = 0; r < 12; r++) begin
        if (r == 0 || r == 1 || r == 2 || r == 3 || r == 9 || r == 10 || r == 11) begin
          wr(8'(r * 4), v);
          rdchk("R2 readback, R3 upper zero", 8'(r * 4), v & PM);
        end
      end
    end
    rdchk("R3 unmask reads zero", 8'h18, 0);
    rdchk("R3 setmask reads zero", 8'h1C, 0);
    rdchk("R3 unmapped 0x30", 8'h30, 0);
    rdchk("R3 unmapped 0x40", 8'h40, 0);
    wr(8'h24, 0); wr(8'h28, 0); wr(8'h2C, 0);

    // R4 pin drivers over direction/enable/bypass combinations
    for (int c = 0; c < 8; c++) begin
      logic [7:0] dv, ev, bv, ov;
      dv = 8'(8'h0F ^ (c * 8'h11));
      ev = 8'(8'hF0 ^ (c * 8'h23));
      bv = 8'(c * 8'h25);
      ov = 8'(8'h96 ^ (c * 8'h07));
      wr(8'h04, {24'd0, dv}); wr(8'h08, {24'd0, ev});
      wr(8'h00, {24'd0, bv}); wr(8'h0C, {24'd0, ov});
      chk("R4 pin_oe", {24'd0, pin_oe}, {24'd0, ev & ~dv & ~bv});
      chk("R4 pin_out", {24'd0, pin_out}, {24'd0, ov});
      chk("R4 pin_alt_sel", {24'd0, pin_alt_sel}, {24'd0, bv});
    end
    wr(8'h00, 0); wr(8'h04, PM); wr(8'h08, 0); wr(8'h0C, 0);

    // R5 synchronised input value; R11 write to input ignored
    for (int c = 0; c < 4; c++) begin
      logic [7:0] pv;
      pv = 8'(8'h3C ^ (c * 8'h55));
      pin_in = pv;
      idle(3);
      rdchk("R5 input value", 8'h10, {24'd0, pv});
    end
    wr(8'h10, 32'h0000_0000);
    rdchk("R11 input write ignored", 8'h10, {24'd0, pin_in});
    pin_in = '0;
    idle(4);
    rd(8'h20, d);

    // R6 mask set/clear; R11 writes to mask readback ignored
    wr(8'h18, 32'h0F);
    rdchk("R6 unmask", 8'h14, 32'hF0);
    wr(8'h1C, 32'h03);
    rdchk("R6 setmask", 8'h14, 32'hF3);
    wr(8'h18, 32'h0);
    rdchk("R6 zero write no change", 8'h14, 32'hF3);
    wr(8'h14, 32'h0);
    rdchk("R11 mask readback write ignored", 8'h14, 32'hF3);
    wr(8'h1C, PM);
    rdchk("R6 mask all", 8'h14, PM);

    // R11 writes to status, unmapped and aliased addresses ignored
    wr(8'h00, 32'h11);
    wr(8'h30, 32'hFF);
    wr(8'h40, 32'hFF);
    wr(8'h20, 32'hFF);
    rdchk("R11 alias write ignored", 8'h00, 32'h11);
    rdchk("R11 status write ignored", 8'h20, 0);
    wr(8'h00, 0);

    // R7 R8 R9 R10 sweep: modes 0 lvl-hi, 1 lvl-lo, 2 rise, 3 fall, 4 both-rise, 5 both-fall
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 6; m++) begin
        bit lvl, hi, bo, base;
        logic [31:0] bit_p;
        logic [NP-1:0] pb;
        string rq;
        lvl  = (m < 2);
        hi   = (m == 0 || m == 2);
        bo   = (m >= 4);
        base = (m == 1 || m == 3 || m == 5);
        rq   = lvl ? "R7" : "R8";
        bit_p = 32'd1 << p;
        pb    = NP'(bit_p);
        wr(8'h24, lvl ? bit_p : 0);
        wr(8'h28, hi ? bit_p : 0);
        wr(8'h2C, bo ? bit_p : 0);
        pin_in = base ? pb : '0;
        idle(4);
        rd(8'h20, d);
        rdchk("R9 cleared by read", 8'h20, 0);
        pin_in = base ? '0 : pb;
        idle(4);
        chk("R10 masked status keeps irq low", {31'd0, irq}, 0);
        wr(8'h18, bit_p);
        chk("R10 unmasked status raises irq", {31'd0, irq}, 1);
        rdchk({rq, " trigger latched"}, 8'h20, bit_p);
        chk("R10 irq after clearing read", {31'd0, irq}, lvl ? 1 : 0);
        rdchk("R9 level re-sets, edge once", 8'h20, lvl ? bit_p : 0);
        wr(8'h1C, bit_p);
        pin_in = base ? pb : '0;
        idle(4);
        rdchk({rq, " release edge"}, 8'h20, (lvl || bo) ? bit_p : 0);
        rdchk("R9 idle after release", 8'h20, 0);
        wr(8'h24, 0); wr(8'h28, 0); wr(8'h2C, 0);
        pin_in = '0;
        idle(4);
        rd(8'h20, d);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule